// File: doc/BRIEF.md
# Two-Input Up/Down Counter with Chainable Carry and Borrow

This block is a binary counter that takes its direction from the input that moves, not from a direction bit. It has two count inputs. A rising edge on the up input adds one to the value, and a rising edge on the down input takes one away. The input that is not in use rests high. A system clock samples both count inputs, and each rising edge is found by comparing the registered sample with the present level.

A synchronous clear forces the value to zero and beats every other input. An active-low load copies a parallel word into the value. While load is low, count edges are dropped.

Two active-low outputs, carry and borrow, mark a wrap that is about to happen. They follow the low phase of the count input that would cause the wrap. A second stage can therefore use them directly as its own count inputs, and the chained stages form one wider counter with no glue logic.

Top module: `updn_dual_counter`

## Requirements
- R1: When `cnt_up` was low in the previous sample and is high at a clock edge, and neither clear nor load is active, the value increases by one at that edge, wrapping from 15 to 0.
- R2: A rising edge on `cnt_dn`, detected the same way under the same conditions, decreases the value by one at that edge, wrapping from 0 to 15.
- R3: `clr` high at a clock edge sets the value to 0 at that edge. This happens whatever `load_n`, `data` and both count inputs are doing.
- R4: `load_n` low with `clr` low copies `data` into the value at the clock edge. Any count edge seen in that cycle is dropped.
- R5: The first count edge after `load_n` returns high acts on the value that was loaded.
- R6: `carry_n` is low exactly when the value is 15 and `cnt_up` is low.
- R7: `borrow_n` is low exactly when the value is 0 and `cnt_dn` is low.
- R8: Rising edges on both count inputs in the same cycle leave the value unchanged.
- R9: When one stage's `carry_n` drives the next stage's `cnt_up` and its `borrow_n` drives the next stage's `cnt_dn`, the pair counts as one 8-bit value. The upper stage steps exactly once per lower-stage wrap, in both directions.
- R10: After reset the value is 0 and both count samples are high, so a count input that is already high after reset does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| load_n | input | 1 | Active-low parallel load |
| data | input | WIDTH | Word to load |
| cnt_up | input | 1 | Count-up input; its rising edge increments the value |
| cnt_dn | input | 1 | Count-down input; its rising edge decrements the value |
| value | output | WIDTH | Present count |
| carry_n | output | 1 | Active-low overflow pulse, as wide as the low phase of `cnt_up` |
| borrow_n | output | 1 | Active-low underflow pulse, as wide as the low phase of `cnt_dn` |

## Verification
Clear, load and count edges all change `value` at the first clock edge that sees them. Count inputs change on a falling clock edge, and the bench reads `value` one full cycle after each input change, on the next falling edge. `carry_n` and `borrow_n` are combinational from `value` and the raw count inputs. They are therefore checked in the middle of a count pulse's low phase, before the rising edge. In the chained pair, the upper stage sees the lower stage's carry or borrow rise at the same clock edge as the lower stage wraps. The 8-bit result is therefore compared at the same falling edge as the lower value.

// File: rtl/udc_pkg.sv
package udc_pkg;
    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_LOAD,
        ACT_INC,
        ACT_DEC
    } udc_act_e;
endpackage

// File: rtl/udc_edge_sense.sv
module udc_edge_sense #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lvl_in,
    output logic [LANES-1:0] rise
);
    typedef struct packed {
        logic [LANES-1:0] samp;
    } sense_t;

    sense_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.samp = lvl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{samp: '1};
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rise[g] = lvl_in[g] & ~st_q.samp[g];
    end
endmodule

// File: rtl/udc_action_sel.sv
module udc_action_sel
    import udc_pkg::*;
(
    input  logic     clr,
    input  logic     load_n,
    input  logic     up_rise,
    input  logic     dn_rise,
    output udc_act_e act
);
    always_comb begin
        if (clr)                     act = ACT_CLEAR;
        else if (!load_n)            act = ACT_LOAD;
        else if (up_rise && dn_rise) act = ACT_HOLD;
        else if (up_rise)            act = ACT_INC;
        else if (dn_rise)            act = ACT_DEC;
        else                         act = ACT_HOLD;
    end
endmodule

// File: rtl/udc_value_reg.sv
module udc_value_reg
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  udc_act_e         act,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } val_t;

    val_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_CLEAR: st_d.cnt = '0;
            ACT_LOAD:  st_d.cnt = data;
            ACT_INC:   st_d.cnt = st_q.cnt + ONE;
            ACT_DEC:   st_d.cnt = st_q.cnt - ONE;
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;
endmodule

// File: rtl/udc_cascade_out.sv
module udc_cascade_out #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    input  logic             cnt_up,
    input  logic             cnt_dn,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic at_top, at_bot;

    always_comb begin
        at_top   = (value == TOP);
        at_bot   = (value == '0);
        carry_n  = ~(at_top & ~cnt_up);
        borrow_n = ~(at_bot & ~cnt_dn);
    end
endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data,
    input  logic             cnt_up,
    input  logic             cnt_dn,
    output logic [WIDTH-1:0] value,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam int LANES = 2;
    localparam int L_UP  = 0;
    localparam int L_DN  = 1;

    logic [LANES-1:0] rise;
    udc_act_e         act;

    udc_edge_sense #(.LANES(LANES)) u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in ({cnt_dn, cnt_up}),
        .rise   (rise)
    );

    udc_action_sel u_sel (
        .clr     (clr),
        .load_n  (load_n),
        .up_rise (rise[L_UP]),
        .dn_rise (rise[L_DN]),
        .act     (act)
    );

    udc_value_reg #(.WIDTH(WIDTH)) u_val (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .data  (data),
        .value (value)
    );

    udc_cascade_out #(.WIDTH(WIDTH)) u_casc (
        .value    (value),
        .cnt_up   (cnt_up),
        .cnt_dn   (cnt_dn),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // R3: clear wins over everything
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));

    // R4: load copies the data word
    a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (value == $past(data)));

    // R1: up edge adds one
    a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && rise[L_UP] && !rise[L_DN]) |=> (value == $past(value) + WIDTH'(1)));

    // R2: down edge takes one away
    a_r2_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && rise[L_DN] && !rise[L_UP]) |=> (value == $past(value) - WIDTH'(1)));

    // R8: simultaneous edges hold
    a_r8_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load_n && rise[L_UP] && rise[L_DN]) |=> $stable(value));

    // R6: carry only while the count-up input is low
    a_r6_carry_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> !cnt_up);

    // R7: borrow only while the count-down input is low
    a_r7_borrow_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> !cnt_dn);
endmodule

// File: tb/sim_updn_dual_counter.sv
module sim_updn_dual_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] d_lo = '0;
    logic [3:0] d_hi = '0;
    logic       up_in = 1'b1;
    logic       dn_in = 1'b1;
    logic [3:0] q_lo, q_hi;
    logic       c_lo, b_lo, c_hi, b_hi;

    int total = 0;
    int bad = 0;
    int model = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    updn_dual_counter #(.WIDTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .data(d_lo),
        .cnt_up(up_in), .cnt_dn(dn_in), .value(q_lo), .carry_n(c_lo), .borrow_n(b_lo)
    );

    updn_dual_counter #(.WIDTH(4)) u1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .data(d_hi),
        .cnt_up(c_lo), .cnt_dn(b_lo), .value(q_hi), .carry_n(c_hi), .borrow_n(b_hi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_pair(input string req);
        chk({q_hi, q_lo} == model[7:0], req, int'({q_hi, q_lo}), model & 255);
    endtask

    task automatic pulse_up();
        @(negedge clk) up_in = 1'b0;
        @(negedge clk);
        chk(c_lo == ((model & 15) != 15), "R6", int'(c_lo), int'((model & 15) != 15));
        chk(b_lo == 1'b1, "R7", int'(b_lo), 1);
        up_in = 1'b1;
        @(negedge clk);
        model = (model + 1) & 255;
    endtask

    task automatic pulse_dn();
        @(negedge clk) dn_in = 1'b0;
        @(negedge clk);
        chk(b_lo == ((model & 15) != 0), "R7", int'(b_lo), int'((model & 15) != 0));
        chk(c_lo == 1'b1, "R6", int'(c_lo), 1);
        dn_in = 1'b1;
        @(negedge clk);
        model = (model - 1) & 255;
    endtask

    task automatic load8(input int v);
        @(negedge clk) begin load_n = 1'b0; d_lo = v[3:0]; d_hi = v[7:4]; end
        @(negedge clk) load_n = 1'b1;
        model = v & 255;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(q_lo == 0 && q_hi == 0, "R10", int'({q_hi, q_lo}), 0);
        chk(c_lo && b_lo, "R10", int'({c_lo, b_lo}), 3);

        // R3 then reference sequence via R1/R2
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        chk_pair("R3");
        load8(13);
        chk(q_lo == 13, "R4", int'(q_lo), 13);
        for (int i = 0; i < 5; i++) begin
            pulse_up();
            chk(q_lo == model[3:0], "R1", int'(q_lo), model & 15);
        end
        for (int i = 0; i < 5; i++) begin
            pulse_dn();
            chk(q_lo == model[3:0], "R2", int'(q_lo), model & 15);
        end
        chk(q_lo == 13, "R2", int'(q_lo), 13);

        // R9: 8-bit sweep up across wraps, then down
        load8(8'hA7);
        chk_pair("R4");
        for (int i = 0; i < 300; i++) begin
            pulse_up();
            chk_pair("R9");
        end
        for (int i = 0; i < 300; i++) begin
            pulse_dn();
            chk_pair("R9");
        end

        // R3: clear beats load, data and a count edge
        @(negedge clk) begin clr = 1'b1; load_n = 1'b0; d_lo = 4'd9; d_hi = 4'd9; up_in = 1'b0; end
        @(negedge clk) up_in = 1'b1;
        @(negedge clk);
        model = 0;
        chk_pair("R3");
        clr = 1'b0; load_n = 1'b1;
        @(negedge clk);

        // R4: count edge during load is dropped
        @(negedge clk) begin load_n = 1'b0; d_lo = 4'h5; d_hi = 4'h4; up_in = 1'b0; end
        @(negedge clk) up_in = 1'b1;
        @(negedge clk) load_n = 1'b1;
        model = 8'h45;
        @(negedge clk);
        chk_pair("R4");
        // R5: first edge after load acts on preset
        pulse_up();
        chk_pair("R5");

        // R8: both edges in one cycle hold
        @(negedge clk) begin up_in = 1'b0; dn_in = 1'b0; end
        @(negedge clk) begin up_in = 1'b1; dn_in = 1'b1; end
        @(negedge clk);
        chk_pair("R8");

        // R6/R7 at the wrap points
        load8(8'h0F);
        @(negedge clk) up_in = 1'b0;
        @(negedge clk) chk(c_lo == 1'b0, "R6", int'(c_lo), 0);
        up_in = 1'b1;
        @(negedge clk);
        chk(c_lo == 1'b1, "R6", int'(c_lo), 1);
        chk({q_hi, q_lo} == 8'h10, "R9", int'({q_hi, q_lo}), 16);
        @(negedge clk) dn_in = 1'b0;
        @(negedge clk) chk(b_lo == 1'b0, "R7", int'(b_lo), 0);
        dn_in = 1'b1;
        @(negedge clk);
        chk({q_hi, q_lo} == 8'h0F, "R9", int'({q_hi, q_lo}), 15);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule